// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Controller

This block gates a bank of differential clock output pairs (true and complement) from one shared source clock. An active-low stop request parks every pair that is marked stoppable. Pairs that are not marked keep toggling, and the rest of the clock tree runs on. A power-down input parks every pair, whatever its mask. A parked pair holds its true output high. Its complement output is released and reads low.

The stop and power-down inputs each pass through two flops clocked on the falling edge. The parked-state register updates only on a rising edge, while the source clock is high. The true output is high at that moment whether or not it is parked, so stopping and resuming never produce a shortened or stretched pulse.

A small write port sets three things. The first is the per-pair stop mask. The second is a per-pair tri-state permission. The third is two global bits that choose whether parked pairs are driven or tri-stated, one bit for a stop and one for a power-down. Each pair reports whether it is currently parked.

Top module: `diff_clk_stop`

## Requirements
- R1: After reset no pair is parked. All true and complement enables are 1. Every pair is stoppable, every pair may be tri-stated, and both tri-state mode bits are 0, so parked pairs are driven.
- R2: A running pair drives `clk_t` equal to `clk_src` and `clk_c` equal to its inverse, with both enables at 1.
- R3: A change of `stop_n` or `pwr_dn` is captured on two successive falling edges of `clk_src`. `stopped` then updates on the next rising edge. Measured from a change made while the clock is high, `stopped` changes 2 cycles later and the first affected low phase starts at the third falling edge.
- R4: A parked pair holds `clk_t` = 1, `clk_c` = 0 and `oe_c` = 0.
- R5: While power-down is inactive, a pair whose stop-mask bit is 0 never parks.
- R6: Deasserting `stop_n` clears `stopped` with the same latency as in R3. Every low phase of `clk_t` lasts exactly half a period. Every high phase lasts half a period plus a whole number of periods.
- R7: A pair parked by a stop has `oe_t` = 0 when both its tri-state permission bit and the stop tri-state bit are 1. Otherwise `oe_t` = 1.
- R8: Power-down parks every pair regardless of the mask and takes priority over the stop input. While power-down holds, `oe_t` = 0 only for pairs whose permission bit and the power-down tri-state bit are both 1.
- R9: A configuration write is captured on a rising edge and is used by the parked-state update from the next rising edge. If the write and a parked-state update fall on the same edge, that update uses the old value. The address and data fields are as follows:
  - Address 0: bits [NPAIRS-1:0] hold the stop mask, and bit 6 selects tri-state on stop.
  - Address 1: bits [NPAIRS-1:0] hold the tri-state permissions, and bit 6 selects tri-state on power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock shared by all pairs |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Active-low stop request |
| pwr_dn | input | 1 | Active-high power-down request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration byte select |
| cfg_wdata | input | 7 | Configuration write data |
| clk_t | output | NPAIRS | True clock outputs |
| clk_c | output | NPAIRS | Complement clock outputs |
| oe_t | output | NPAIRS | True output enables |
| oe_c | output | NPAIRS | Complement output enables |
| stopped | output | NPAIRS | Per-pair parked status |

## Verification
A configuration write can land on the same rising edge at which a synchronized stop request first updates the parked state. The bench provokes this by timing a mask-clearing write so that it is captured on exactly that edge. It then expects every pair parked for one cycle, under the old mask, and every pair running again one cycle later. A second coincidence is power-down and stop held together with opposite tri-state settings. There the table expects all pairs parked and driven, as the power-down rules require.

// File: rtl/diff_clk_stop.sv
`timescale 1ns/1ps
module diff_clk_stop #(
  parameter int NPAIRS = 6
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              stop_n,
  input  logic              pwr_dn,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [6:0]        cfg_wdata,
  output logic [NPAIRS-1:0] clk_t,
  output logic [NPAIRS-1:0] clk_c,
  output logic [NPAIRS-1:0] oe_t,
  output logic [NPAIRS-1:0] oe_c,
  output logic [NPAIRS-1:0] stopped
);
  localparam int MODE_BIT = 6;

  logic [1:0]        stp_sync, pd_sync;
  logic [NPAIRS-1:0] stop_mask, tri_en, stopped_q;
  logic              flt_stop, flt_pd, pd_q, float_now;

  // request capture on falling edges
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      stp_sync <= 2'b00;
      pd_sync  <= 2'b00;
    end else begin
      stp_sync <= {stp_sync[0], ~stop_n};
      pd_sync  <= {pd_sync[0], pwr_dn};
    end
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      stop_mask <= '1;
      tri_en    <= '1;
      flt_stop  <= 1'b0;
      flt_pd    <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr) begin
        tri_en <= cfg_wdata[NPAIRS-1:0];
        flt_pd <= cfg_wdata[MODE_BIT];
      end else begin
        stop_mask <= cfg_wdata[NPAIRS-1:0];
        flt_stop  <= cfg_wdata[MODE_BIT];
      end
    end
  end

  // gate state moves only while clk_src is high
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= '0;
      pd_q      <= 1'b0;
    end else begin
      pd_q      <= pd_sync[1];
      stopped_q <= pd_sync[1] ? '1 : (stp_sync[1] ? stop_mask : '0);
    end
  end

  assign float_now = pd_q ? flt_pd : flt_stop;
  assign stopped   = stopped_q;

  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    assign clk_t[i] = clk_src | stopped_q[i];
    assign clk_c[i] = ~clk_src & ~stopped_q[i];
    assign oe_t[i]  = ~(stopped_q[i] & tri_en[i] & float_now);
    assign oe_c[i]  = ~stopped_q[i];
  end
endmodule

module diff_clk_stop_chk #(
  parameter int NPAIRS = 6
) (
  input logic              clk_src,
  input logic              rst_n,
  input logic [1:0]        stp_sync,
  input logic [1:0]        pd_sync,
  input logic [NPAIRS-1:0] stop_mask,
  input logic [NPAIRS-1:0] tri_en,
  input logic              flt_stop,
  input logic              flt_pd,
  input logic              pd_q,
  input logic [NPAIRS-1:0] stopped_q,
  input logic [NPAIRS-1:0] clk_t,
  input logic [NPAIRS-1:0] clk_c,
  input logic [NPAIRS-1:0] oe_t,
  input logic [NPAIRS-1:0] oe_c
);
  for (genvar i = 0; i < NPAIRS; i++) begin : g_chk
    a_r2_running_follows: assert property (@(posedge clk_src) disable iff (!rst_n)
      !stopped_q[i] |-> (!clk_t[i] && clk_c[i] && oe_c[i]));
    a_r4_parked_level: assert property (@(posedge clk_src) disable iff (!rst_n)
      stopped_q[i] |-> (clk_t[i] && !clk_c[i] && !oe_c[i]));
    a_r3_needs_request: assert property (@(posedge clk_src) disable iff (!rst_n)
      $rose(stopped_q[i]) |-> ($past(stp_sync[1]) || $past(pd_sync[1])));
    a_r5_unmasked_runs: assert property (@(posedge clk_src) disable iff (!rst_n)
      (!pd_sync[1] && !stop_mask[i]) |=> !stopped_q[i]);
    a_r8_pd_parks_all: assert property (@(posedge clk_src) disable iff (!rst_n)
      pd_sync[1] |=> stopped_q[i]);
    a_r7_float_on_stop: assert property (@(posedge clk_src) disable iff (!rst_n)
      (stopped_q[i] && !pd_q && flt_stop && tri_en[i]) |-> !oe_t[i]);
    a_r8_pd_driven: assert property (@(posedge clk_src) disable iff (!rst_n)
      (stopped_q[i] && pd_q && !flt_pd) |-> oe_t[i]);
  end
endmodule

bind diff_clk_stop diff_clk_stop_chk #(.NPAIRS(NPAIRS)) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .stp_sync(stp_sync), .pd_sync(pd_sync),
  .stop_mask(stop_mask), .tri_en(tri_en), .flt_stop(flt_stop), .flt_pd(flt_pd),
  .pd_q(pd_q), .stopped_q(stopped_q), .clk_t(clk_t), .clk_c(clk_c),
  .oe_t(oe_t), .oe_c(oe_c)
);

// File: tb/test_diff_clk_stop.sv
`timescale 1ns/1ps
module test_diff_clk_stop;
  localparam int PERIOD = 10;
  localparam int HALF = PERIOD / 2;
  localparam int NP = 6;

  // {stop_n, pwr_dn, mask[5:0], flt_stop, flt_pd, tri_en[5:0], exp_stopped[5:0], exp_oe_t[5:0]}
  localparam logic [27:0] VEC [10] = '{
    {1'b1, 1'b0, 6'h3F, 1'b0, 1'b0, 6'h3F, 6'h00, 6'h3F},
    {1'b0, 1'b0, 6'h3F, 1'b0, 1'b0, 6'h3F, 6'h3F, 6'h3F},
    {1'b0, 1'b0, 6'h15, 1'b0, 1'b0, 6'h3F, 6'h15, 6'h3F},
    {1'b0, 1'b0, 6'h2A, 1'b1, 1'b0, 6'h3F, 6'h2A, 6'h15},
    {1'b0, 1'b0, 6'h3F, 1'b1, 1'b0, 6'h0F, 6'h3F, 6'h30},
    {1'b1, 1'b0, 6'h2A, 1'b1, 1'b0, 6'h3F, 6'h00, 6'h3F},
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b0, 6'h3F, 6'h3F, 6'h3F},
    {1'b1, 1'b1, 6'h00, 1'b0, 1'b1, 6'h33, 6'h3F, 6'h0C},
    {1'b0, 1'b1, 6'h03, 1'b1, 1'b0, 6'h3F, 6'h3F, 6'h3F},
    {1'b1, 1'b0, 6'h3F, 1'b0, 1'b0, 6'h3F, 6'h00, 6'h3F}
  };

  logic clk = 1'b0, rst_n = 1'b0, stop_n = 1'b1, pwr_dn = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [NP-1:0] clk_t, clk_c, oe_t, oe_c, stopped;
  int nchk = 0, nerr = 0, bad_pulses = 0, pulses = 0;
  bit done = 0, mon_on = 0, have_last = 0;
  longint t_last = 0, w = 0;

  always #HALF clk = ~clk;

  diff_clk_stop #(.NPAIRS(NP)) i_diff_clk_stop (
    .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .pwr_dn(pwr_dn),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .clk_t(clk_t), .clk_c(clk_c), .oe_t(oe_t), .oe_c(oe_c), .stopped(stopped)
  );

  always @(clk_t[0]) begin
    if (mon_on) begin
      if (have_last) begin
        w = $time - t_last;
        pulses++;
        if (clk_t[0] === 1'b1) begin
          if (w != HALF) bad_pulses++;
        end else if (w < HALF || ((w - HALF) % PERIOD) != 0) bad_pulses++;
      end
      have_last = 1;
      t_last = $time;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic a, input logic [6:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 reset state", {stopped, oe_t, oe_c, clk_t, clk_c}, {6'h00, 6'h3F, 6'h3F, 6'h00, 6'h3F});
    #19 rst_n = 1'b1;
    @(posedge clk); #2;
    mon_on = 1;
    chk("R2 running pair", {clk_t, clk_c, oe_t, oe_c}, {6'h3F, 6'h00, 6'h3F, 6'h3F});

    // R3 stop latency with reset-default mask and driven mode (R1)
    stop_n = 1'b0;
    #16 chk("R3 not yet stopped", {stopped, clk_t}, {6'h00, 6'h00});
    #5  chk("R3 R1 stopped after two falls, default mask", {stopped, oe_t}, {6'h3F, 6'h3F});
    #5  chk("R4 parked levels", {clk_t, clk_c, oe_c}, {6'h3F, 6'h00, 6'h00});
    repeat (3) @(posedge clk);
    #2 stop_n = 1'b1;
    #16 chk("R6 still parked before resume", {stopped, clk_t}, {6'h3F, 6'h3F});
    #5  chk("R6 stopped clears", stopped, 6'h00);
    #5  chk("R6 first low after resume", {clk_t, clk_c, oe_c}, {6'h00, 6'h3F, 6'h3F});

    // R9 mask write on the same edge as the parked-state update
    @(posedge clk); #2;
    stop_n = 1'b0;
    #10 cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 7'h00;
    #10 cfg_we = 1'b0;
    #1  chk("R9 same-edge write uses old mask", stopped, 6'h3F);
    #10 chk("R9 R5 new mask next edge", stopped, 6'h00);
    chk("R5 unmasked pairs toggle", {clk_t, clk_c}, {6'h3F, 6'h00});
    cfg_write(1'b0, 7'h3F);
    stop_n = 1'b1;
    repeat (4) @(posedge clk);

    // table: R4 R5 R7 R8
    for (int k = 0; k < 10; k++) begin
      logic [27:0] v;
      v = VEC[k];
      cfg_write(1'b0, {v[19], v[25:20]});
      cfg_write(1'b1, {v[18], v[17:12]});
      @(posedge clk); #2;
      stop_n = v[27]; pwr_dn = v[26];
      repeat (4) @(posedge clk);
      #7;
      chk($sformatf("R4 R5 R7 R8 table vector %0d", k),
          {stopped, oe_t, oe_c, clk_t, clk_c},
          {v[11:6], v[5:0], ~v[11:6], v[11:6], ~v[11:6]});
    end

    chk("R6 no runt or stretched pulse on pair 0", bad_pulses, 0);
    chk("R6 pulses observed", (pulses > 20) ? 1 : 0, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule